// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt inputs and presents one active-high request line to a processor. Each input has its own mode word, which selects one of eight priority levels (0 lowest, 7 highest) and one of four trigger styles, and its own vector word, which is handed back when that input is serviced. Software programs the controller over a simple synchronous register bus with an address, a write strobe, a read strobe, write data and registered read data.

The processor services a request by reading the acknowledge location. The read returns the vector of the winning input, records the winner's priority on an 8-deep nesting stack and drops the request line. While a priority sits on top of the stack, only an input with a strictly higher priority can raise the line again. Each write to the end-of-service location removes one stack level. If nothing qualifies when the acknowledge location is read, the programmable spurious vector is returned and the stack is left unchanged.

Edge-triggered inputs pass through a two-flop synchroniser and stay latched until they are serviced or cleared by software. Level-triggered inputs follow the synchronised pin and are never latched.

Top module: `vpic`

## Requirements
- R1: After reset, the request line is low, every input is disabled, every mode word reads 0x10 (trigger code 2, priority 0), the spurious vector reads 0, and an acknowledge read returns 0.
- R2: Writing 1s to the enable-set location (0x41) enables those inputs. Writing 1s to the enable-clear location (0x42) disables them. Zero bits change nothing. The mask location (0x43) reads back the enable bits, bit i for input i.
- R3: A mode word (address i, 0 to 31) holds the priority in bits [2:0] and the trigger code in bits [4:3], where 0 = high level, 1 = rising edge, 2 = low level and 3 = falling edge. Inputs 0 and 25 to 31 accept every code. On inputs 1 to 24, a write with code 2 or 3 is ignored entirely.
- R4: A level-triggered input is active while its synchronised pin is at the selected level. It stops requesting once the pin leaves that level.
- R5: A rising or falling edge on the synchronised pin of an edge-triggered input is latched. The latch stays set after the pin returns to its old level.
- R6: Writing a 1 to bit i of the edge-clear location (0x44) clears input i's latched edge.
- R7: Among enabled, active inputs that qualify, the highest priority wins. Equal priorities resolve to the lowest input number.
- R8: A read of the acknowledge location (0x40) while some input qualifies returns that input's vector (location 0x20+i), pushes its priority and clears its latched edge. The request line is low in the following cycle.
- R9: An acknowledge read while nothing qualifies returns the spurious vector (location 0x45) and leaves the stack unchanged.
- R10: An input qualifies only if the stack is empty or its priority is strictly above the stack top.
- R11: Each write to the end-of-service location (0x46) pops one level. Eight such writes unwind eight nested acknowledges. A write to an empty stack has no effect.
- R12: The request line is registered. It goes high one clock after some input qualifies, except in a cycle that performs an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Raw interrupt inputs, one bit per source |
| bus_addr | input | 8 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of 0x40 acknowledges |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
A behavioural model in the bench tracks enables, latches, the stack and the request line, and is compared on every clock. The stimulus covers several patterns. Single level inputs of both polarities are driven and then released, which tells latched behaviour from unlatched. Short pulses on edge inputs of both polarities show that the edge is held. Simultaneous pulses at equal and unequal priorities test the winner order and the lowest-index tie break. An ascending staircase of priorities builds a full eight-level nesting, which tests the strict-greater rule and shows that exactly eight end-of-service writes unwind it. Illegal mode writes, edge clears and acknowledges with nothing pending check that the ignored, cleared and spurious paths leave the outputs as required.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    TRG_HIGH = 2'd0,
    TRG_RISE = 2'd1,
    TRG_LOW  = 2'd2,
    TRG_FALL = 2'd3
  } trig_e;

  // mode word field positions
  localparam int MODE_PRIO_LSB = 0;
  localparam int MODE_TRIG_LSB = 3;

  // global register offsets above the vector region
  localparam int OFS_ACK     = 0;
  localparam int OFS_ENSET   = 1;
  localparam int OFS_ENCLR   = 2;
  localparam int OFS_MASK    = 3;
  localparam int OFS_EDGECLR = 4;
  localparam int OFS_SPUR    = 5;
  localparam int OFS_EOI     = 6;

endpackage

// File: rtl/vpic_src_cond.sv
module vpic_src_cond
  import vpic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      src_in,
  input  logic [N_SRC-1:0][1:0] trig,
  input  logic [N_SRC-1:0]      edge_clr,
  output logic [N_SRC-1:0]      active
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic s1_q, s2_q, s3_q, lat_q;
    logic set_edge;

    assign set_edge = ((trig[i] == TRG_RISE) &&  s2_q && !s3_q) ||
                      ((trig[i] == TRG_FALL) && !s2_q &&  s3_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        s3_q  <= 1'b0;
        lat_q <= 1'b0;
      end else begin
        s1_q  <= src_in[i];
        s2_q  <= s1_q;
        s3_q  <= s2_q;
        lat_q <= (lat_q && !edge_clr[i]) || set_edge;
      end
    end

    always_comb begin
      unique case (trig[i])
        TRG_HIGH: active[i] = s2_q;
        TRG_LOW:  active[i] = !s2_q;
        default:  active[i] = lat_q;
      endcase
    end

    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (edge_clr[i] && !set_edge) |=> !lat_q);
  end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SRC-1:0]           req,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                       any,
  output logic [IDX_W-1:0]           win_idx,
  output logic [PRIO_W-1:0]          win_prio
);

  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!any || prio[i] > win_prio)) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end

  assert_winner_requests_R7: assert property (@(posedge clk) disable iff (rst)
    any |-> req[win_idx]);

  assert_none_means_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !any |-> (req == '0));

endmodule

// File: rtl/vpic_nest_stack.sv
module vpic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic              top_valid,
  output logic [PRIO_W-1:0] top_prio
);

  logic [DEPTH-1:0][PRIO_W-1:0] stk_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             cnt_popped;

  assign cnt_popped = (pop && cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
  assign top_valid  = (cnt_q != '0);
  assign top_prio   = top_valid ? stk_q[PTR_W'(cnt_q - CNT_W'(1))] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stk_q <= '0;
    end else begin
      if (push) stk_q[PTR_W'(cnt_popped)] <= push_prio;
      cnt_q <= cnt_popped + CNT_W'(push);
    end
  end

  assert_no_push_when_full_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt_q < CNT_W'(DEPTH)));

  assert_pop_drops_one_R11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_pop_empty_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/vpic.sv
module vpic
  import vpic_pkg::*;
#(
  parameter int N_SRC     = 32,
  parameter int PRIO_W    = 3,
  parameter int NEST      = 8,
  parameter int EXT_FIRST = 25,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int IDX_W    = $clog2(N_SRC);
  localparam int VEC_BASE = N_SRC;
  localparam int GBL_BASE = 2 * N_SRC;

  // ---------------- address decode ----------------
  logic             in_mode, in_vec;
  logic [IDX_W-1:0] a_idx;
  logic             hit_ack, hit_set, hit_clr, hit_mask, hit_eclr, hit_spur, hit_eoi;

  assign in_mode  = bus_addr < ADDR_W'(VEC_BASE);
  assign in_vec   = (bus_addr >= ADDR_W'(VEC_BASE)) && (bus_addr < ADDR_W'(GBL_BASE));
  assign a_idx    = bus_addr[IDX_W-1:0];
  assign hit_ack  = bus_addr == ADDR_W'(GBL_BASE + OFS_ACK);
  assign hit_set  = bus_addr == ADDR_W'(GBL_BASE + OFS_ENSET);
  assign hit_clr  = bus_addr == ADDR_W'(GBL_BASE + OFS_ENCLR);
  assign hit_mask = bus_addr == ADDR_W'(GBL_BASE + OFS_MASK);
  assign hit_eclr = bus_addr == ADDR_W'(GBL_BASE + OFS_EDGECLR);
  assign hit_spur = bus_addr == ADDR_W'(GBL_BASE + OFS_SPUR);
  assign hit_eoi  = bus_addr == ADDR_W'(GBL_BASE + OFS_EOI);

  logic [PRIO_W-1:0] w_prio;
  logic [1:0]        w_trig;
  assign w_prio = bus_wdata[MODE_PRIO_LSB +: PRIO_W];
  assign w_trig = bus_wdata[MODE_TRIG_LSB +: 2];

  // ---------------- state ----------------
  logic [N_SRC-1:0]              en_q;
  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [N_SRC-1:0][1:0]         trig_q;
  logic [DATA_W-1:0]             spur_q;
  logic [DATA_W-1:0]             vec_mem [N_SRC];

  logic [N_SRC-1:0] active, elig, edge_clr;
  logic             cand_any;
  logic [IDX_W-1:0] win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic             top_valid;
  logic [PRIO_W-1:0] top_prio;
  logic             ack_fire, ack_hit, eoi_fire;

  assign ack_fire = bus_re && hit_ack;
  assign ack_hit  = ack_fire && cand_any;
  assign eoi_fire = bus_we && hit_eoi;

  // ---------------- per-source mode words ----------------
  for (genvar i = 0; i < N_SRC; i++) begin : g_mode
    localparam bit ALL_TRIG = (i == 0) || (i >= EXT_FIRST);
    logic wr_ok;

    assign wr_ok = bus_we && in_mode && (a_idx == IDX_W'(i)) &&
                   (ALL_TRIG || !w_trig[1]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRG_LOW;
      end else if (wr_ok) begin
        prio_q[i] <= w_prio;
        trig_q[i] <= w_trig;
      end
    end

    assign elig[i]     = en_q[i] && active[i] && (!top_valid || prio_q[i] > top_prio);
    assign edge_clr[i] = (bus_we && hit_eclr && bus_wdata[i]) ||
                         (ack_hit && win_idx == IDX_W'(i));

    if (!ALL_TRIG) begin : g_chk
      assert_illegal_mode_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && in_mode && a_idx == IDX_W'(i) && w_trig[1]) |=> $stable(trig_q[i]));
    end
  end

  // ---------------- enables and spurious vector ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      spur_q <= '0;
    end else if (bus_we) begin
      if (hit_set)  en_q   <= en_q | bus_wdata[N_SRC-1:0];
      if (hit_clr)  en_q   <= en_q & ~bus_wdata[N_SRC-1:0];
      if (hit_spur) spur_q <= bus_wdata;
    end
  end

  // ---------------- submodules ----------------
  vpic_src_cond #(.N_SRC(N_SRC)) u_cond (
    .clk(clk), .rst(rst), .src_in(src_in), .trig(trig_q),
    .edge_clr(edge_clr), .active(active)
  );

  vpic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst(rst), .req(elig), .prio(prio_q),
    .any(cand_any), .win_idx(win_idx), .win_prio(win_prio)
  );

  vpic_nest_stack #(.DEPTH(NEST), .PRIO_W(PRIO_W)) u_stack (
    .clk(clk), .rst(rst), .push(ack_hit), .push_prio(win_prio), .pop(eoi_fire),
    .top_valid(top_valid), .top_prio(top_prio)
  );

  // ---------------- vector memory (single read port) ----------------
  logic [IDX_W-1:0]  mem_ridx;
  logic [DATA_W-1:0] mem_q, reg_q;
  logic              sel_mem_q;

  assign mem_ridx = ack_fire ? win_idx : a_idx;

  always_ff @(posedge clk) begin
    if (bus_we && in_vec) vec_mem[a_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (bus_re) mem_q <= vec_mem[mem_ridx];
  end

  // ---------------- read data and request ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (bus_re) begin
      sel_mem_q <= in_vec || ack_hit;
      if (in_mode)       reg_q <= DATA_W'({trig_q[a_idx], prio_q[a_idx]});
      else if (hit_ack)  reg_q <= spur_q;
      else if (hit_mask) reg_q <= DATA_W'(en_q);
      else if (hit_spur) reg_q <= spur_q;
      else               reg_q <= '0;
    end
  end

  assign bus_rdata = sel_mem_q ? mem_q : reg_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= cand_any && !ack_fire;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:MODE_TRIG_LSB+2], bus_addr};

  // ---------------- assertions ----------------
  assert_irq_low_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> !irq);

  assert_spurious_read_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !cand_any) |=> (bus_rdata == $past(spur_q)));

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_set) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  assert_enable_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_clr) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  assert_irq_follows_cand_R12: assert property (@(posedge clk) disable iff (rst)
    (cand_any && !ack_fire) |=> irq);

endmodule

// File: tb/vpic_bench.sv
module vpic_bench;
  localparam int A_ACK = 8'h40, A_SET = 8'h41, A_CLR = 8'h42, A_MASK = 8'h43;
  localparam int A_ECL = 8'h44, A_SPUR = 8'h45, A_EOI = 8'h46, A_VEC = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = 32'hFE00_0000;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  vpic u_vpic (.clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
               .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
               .bus_rdata(bus_rdata), .irq(irq));

  // ---------------- behavioural reference ----------------
  bit [31:0] m_en, m_lat, s1, s2, s3;
  int        m_prio[32], m_trig[32], m_vec[32];
  int        m_spur, m_rdata;
  int        m_stk[$];
  bit        m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_lat = 0; s1 = 0; s2 = 0; s3 = 0;
      for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 2; end
      m_spur = 0; m_rdata = 0; m_stk.delete(); m_irq = 0;
    end else begin
      int top, best, bp;
      bit ack;
      bit [31:0] setv, clrv;
      top  = (m_stk.size() > 0) ? m_stk[$] : -1;
      best = -1; bp = -1;
      for (int i = 0; i < 32; i++) begin
        bit act;
        case (m_trig[i])
          0: act = s2[i];
          2: act = !s2[i];
          default: act = m_lat[i];
        endcase
        if (m_en[i] && act && m_prio[i] > top && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
      end
      ack = bus_re && bus_addr == A_ACK;
      for (int i = 0; i < 32; i++) begin
        setv[i] = (m_trig[i] == 1 && s2[i] && !s3[i]) || (m_trig[i] == 3 && !s2[i] && s3[i]);
        clrv[i] = (bus_we && bus_addr == A_ECL && bus_wdata[i]) || (ack && best == i);
      end
      if (bus_re) begin
        if (bus_addr < 32)      m_rdata = m_prio[bus_addr] | (m_trig[bus_addr] << 3);
        else if (bus_addr < 64) m_rdata = m_vec[bus_addr - 32];
        else if (ack)           m_rdata = (best >= 0) ? m_vec[best] : m_spur;
        else if (bus_addr == A_MASK) m_rdata = m_en;
        else if (bus_addr == A_SPUR) m_rdata = m_spur;
        else m_rdata = 0;
      end
      if (bus_we) begin
        if (bus_addr < 32) begin
          if (bus_addr == 0 || bus_addr >= 25 || bus_wdata[4] == 0) begin
            m_prio[bus_addr] = bus_wdata[2:0]; m_trig[bus_addr] = bus_wdata[4:3];
          end
        end else if (bus_addr < 64) m_vec[bus_addr - 32] = bus_wdata;
        else if (bus_addr == A_SET)  m_en = m_en | bus_wdata;
        else if (bus_addr == A_CLR)  m_en = m_en & ~bus_wdata;
        else if (bus_addr == A_SPUR) m_spur = bus_wdata;
        else if (bus_addr == A_EOI && m_stk.size() > 0) void'(m_stk.pop_back());
      end
      if (ack && best >= 0) m_stk.push_back(bp);
      m_lat = (m_lat & ~clrv) | setv;
      m_irq = (best >= 0) && !ack;
      s3 = s2; s2 = s1; s1 = src_in;
    end
  end

  // R12: request line compared with the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R12 irq at %0t: actual=%0b expected=%0b", $time, irq, m_irq);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input int a, input string tag, output int d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
    check({tag, " model"}, d, m_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    src_in[i] = ~src_in[i]; idle(3);
    src_in[i] = ~src_in[i]; idle(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    idle(3); rst = 0; idle(2);

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(A_MASK, "R1 mask", d);  check("R1 mask", d, 0);
    rd(5, "R1 mode", d);       check("R1 mode", d, 32'h10);
    rd(A_SPUR, "R1 spur", d);  check("R1 spur", d, 0);
    rd(A_ACK, "R1 ack", d);    check("R1 ack", d, 0);

    for (int i = 0; i < 32; i++) wr(A_VEC + i, 32'h100 + i);
    wr(A_SPUR, 32'hDEAD);

    // R2 enable set / clear / mask
    wr(A_SET, 32'hF0);
    rd(A_MASK, "R2 mask", d);  check("R2 set", d, 32'hF0);
    wr(A_CLR, 32'h30);
    rd(A_MASK, "R2 mask", d);  check("R2 clear", d, 32'hC0);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_MASK, "R2 mask", d);  check("R2 all clear", d, 0);
    idle(4);

    // R3 mode legality
    wr(5, 32'h03);
    rd(5, "R3 mode", d);       check("R3 legal high", d, 32'h03);
    wr(5, 32'h16);
    rd(5, "R3 mode", d);       check("R3 low ignored", d, 32'h03);
    wr(0, 32'h16);
    rd(0, "R3 mode", d);       check("R3 src0 low", d, 32'h16);
    wr(27, 32'h1A);
    rd(27, "R3 mode", d);      check("R3 ext falling", d, 32'h1A);

    // R4 level triggers
    wr(3, 32'h02); wr(A_SET, 32'h8);
    src_in[3] = 1; idle(5);    check("R4 high level", irq, 1);
    src_in[3] = 0; idle(5);    check("R4 not latched", irq, 0);
    wr(26, 32'h11); wr(A_SET, 32'h1 << 26); idle(4);
    check("R4 low idle", irq, 0);
    src_in[26] = 0; idle(5);   check("R4 low level", irq, 1);
    rd(A_ACK, "R8 ack", d);    check("R8 vec26", d, 32'h11A);
    check("R8 irq drop", irq, 0);
    src_in[26] = 1; idle(5);
    wr(A_EOI, 0); idle(3);     check("R4 low released", irq, 0);

    // R5 edges
    wr(10, 32'h0C); wr(A_SET, 32'h1 << 10);
    pulse(10);                 check("R5 rising latched", irq, 1);
    rd(A_ACK, "R8 ack", d);    check("R8 vec10", d, 32'h10A);
    wr(A_EOI, 0); idle(3);     check("R8 edge cleared by ack", irq, 0);
    wr(30, 32'h1D); wr(A_SET, 32'h1 << 30);
    pulse(30);                 check("R5 falling latched", irq, 1);
    rd(A_ACK, "R8 ack", d);    check("R8 vec30", d, 32'h11E);
    wr(A_EOI, 0); idle(3);

    // R6 edge clear, R9 spurious
    pulse(10);                 check("R6 pre", irq, 1);
    wr(A_ECL, 32'h1 << 10); idle(2);
    check("R6 cleared", irq, 0);
    rd(A_ACK, "R9 ack", d);    check("R9 spurious", d, 32'hDEAD);

    // R7 / R10 priority and nesting
    wr(12, 32'h0C); wr(20, 32'h0C); wr(A_SET, (32'h1 << 12) | (32'h1 << 20));
    src_in[3] = 1;
    src_in[12] = 1; src_in[20] = 1; idle(3); src_in[12] = 0; src_in[20] = 0; idle(5);
    rd(A_ACK, "R7 ack", d);    check("R7 tie lowest", d, 32'h10C);
    idle(4);                   check("R10 equal blocked", irq, 0);
    wr(A_EOI, 0); idle(3);     check("R11 pop reopens", irq, 1);
    rd(A_ACK, "R7 ack", d);    check("R7 second", d, 32'h114);
    wr(A_EOI, 0); idle(3);
    rd(A_ACK, "R7 ack", d);    check("R7 lower prio", d, 32'h103);
    pulse(10);                 check("R10 higher nests", irq, 1);
    rd(A_ACK, "R10 ack", d);   check("R10 nested vec", d, 32'h10A);
    src_in[3] = 0; idle(5);
    wr(A_EOI, 0); wr(A_EOI, 0); idle(3);
    check("R11 unwound", irq, 0);

    // R11 eight-deep nesting
    wr(A_CLR, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) wr(11 + k, 32'h08 | k);
    wr(A_SET, 32'hFF << 11);
    for (int k = 0; k < 8; k++) begin
      pulse(11 + k);
      rd(A_ACK, "R11 ack", d); check("R11 stair", d, 32'h100 + 11 + k);
    end
    pulse(18);                 check("R10 top equal", irq, 0);
    wr(A_ECL, 32'h1 << 18);
    pulse(11);
    for (int k = 0; k < 7; k++) wr(A_EOI, 0);
    idle(3);                   check("R11 seven pops", irq, 0);
    wr(A_EOI, 0); idle(3);     check("R11 eight pops", irq, 1);
    rd(A_ACK, "R11 ack", d);   check("R11 after unwind", d, 32'h10B);
    wr(A_EOI, 0); wr(A_EOI, 0); idle(3);
    check("R11 empty pop", irq, 0);
    pulse(11);                 check("R11 stack empty", irq, 1);
    rd(A_ACK, "R11 ack", d);   check("R11 final", d, 32'h10B);
    rd(A_ACK, "R9 ack", d);    check("R9 none", d, 32'hDEAD);

    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule